// File: doc/BRIEF.md
# SPI EEPROM command controller

This block is the serial front end of a 512-byte non-volatile memory. It behaves as an SPI slave in mode 0 and takes byte-wide commands over SCK, an active-low chip select, SI and SO. It holds the memory as an internal register array, and a status register of its own that carries a write-enable latch, a busy flag, two block-lock bits and two watchdog-period bits. The watchdog bits are brought out to a neighbouring supervisor.

All serial pins are synchronised into the system clock and their edges are detected there. Reads stream bytes from successive addresses for as long as clocks keep coming. Writes collect up to one page of 16 bytes in a buffer. A write is committed only when chip select closes on a clean byte boundary, the latch is set, the write-protect pin is high and the target page is not locked. A committed write or status write starts a self-timed cycle of `WR_CYCLES` clocks. The memory or status bits change at the end of that cycle.

Top module: `spi_ee_ctrl`

## Requirements
- R1: SI is sampled on SCK rising edges and all fields go MSB first. SO changes only after SCK falling edges. `so_oe` is 0 while `cs_n` is high and during the opcode and address bytes of a read.
- R2: Opcode 06h sets the write-enable latch and 04h clears it. Either takes effect only when `cs_n` rises after a whole number of bytes; a trailing partial byte cancels it.
- R3: Opcode 05h returns status bytes with bit 7..0 = 0, 0, watchdog[1], watchdog[0], lock[1], lock[0], latch, busy. The value after reset is 30h, and `wd_sel` always equals status bits 5:4.
- R4: Read opcode 0000_A011b (bit 3 = address bit 8) is followed by one address byte. Data then streams from successive addresses and wraps from 1FFh to 000h.
- R5: Write opcode 0000_A010b (bit 3 = address bit 8) is followed by an address byte and data bytes. The low 4 address bits wrap inside the 16-byte page, so later bytes replace earlier ones.
- R6: A write or status write commits only if `cs_n` rises with zero bits pending after at least one complete data byte. Otherwise nothing changes and no cycle starts.
- R7: A write needs the latch set and `wp_n` high when `cs_n` rises. The latch is held cleared while `wp_n` is low.
- R8: Lock code 00 protects nothing, 01 protects 180h-1FFh, 10 protects 100h-1FFh and 11 protects everything. A write to a protected page commits nothing and starts no cycle. Protected bytes still read normally.
- R9: A committed write sets the busy bit for `WR_CYCLES` clocks. At the end of that cycle the stored data is updated and the latch is cleared.
- R10: While busy, every opcode except 05h is ignored. This includes reads, which leave `so_oe` low.
- R11: Opcode 01h with one data byte updates only status bits 5:2 at the end of the cycle. It needs the latch and `wp_n` high, and bits 7:6 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so` |
| wd_sel | output | 2 | Watchdog-period bits from the status register |

## Verification
A wrong bit counter or opcode decode shows up at once. The status byte read right after a transaction carries the wrong latch or busy bit, and the next read returns shifted or wrong data. Corruption in the page buffer, the protect decode or the commit gate stays hidden until the write cycle ends. It then appears as a wrong byte on the next read of that page, or as a latch that stays set because no cycle ran. For this reason every write is followed by a status poll and a read-back, and protection is swept over all four lock codes at addresses on both sides of each boundary.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    ST_OPC,    // waiting for the opcode byte
    ST_ADR,    // collecting the low address byte
    ST_RDA,    // streaming array bytes out
    ST_WDA,    // collecting page data
    ST_RST,    // streaming the status byte out
    ST_WST,    // collecting the status data byte
    ST_LATCH,  // latch set or clear, waiting for deselect
    ST_SKIP    // command ignored until deselect
  } ee_state_e;

  typedef enum logic {
    JOB_ARRAY,
    JOB_STAT
  } ee_job_e;

  localparam logic [7:0] OP_LATCH_ON  = 8'h06;
  localparam logic [7:0] OP_LATCH_OFF = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [2:0] OP_LO_READ   = 3'b011;
  localparam logic [2:0] OP_LO_WRITE  = 3'b010;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int          N       = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic         rst_ln,
  output logic [N-1:0] lvl
);

  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_ln = rst_pipe_q[1];

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_ln) begin
      if (!rst_ln) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_in[g];
        stab_q <= meta_q;
      end
    end
    assign lvl[g] = stab_q;
  end

endmodule

// File: rtl/spi_ee_guard.sv
module spi_ee_guard #(
  parameter int AW = 9
) (
  input  logic [1:0]    lock,
  input  logic [AW-1:0] addr,
  output logic          prot
);

  always_comb begin
    unique case (lock)
      2'b00:   prot = 1'b0;
      2'b01:   prot = addr[AW-1] & addr[AW-2];
      2'b10:   prot = addr[AW-1];
      default: prot = 1'b1;
    endcase
  end

endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_ln,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == ONE);

  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    start |-> !busy);

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  input  logic       wp_n,
  output logic       so,
  output logic       so_oe,
  output logic [1:0] wd_sel
);

  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int GW    = AW - PW;
  localparam logic [PW-1:0] PONE = PW'(1);
  localparam logic [AW-1:0] AONE = AW'(1);

  // synchronised pins: 0 sck, 1 cs_n, 2 si, 3 wp_n
  logic       rst_ln;
  logic [3:0] pin_s;
  logic       sck_s, csn_s, si_s, wpn_s;

  spi_ee_sync #(.N(4), .RST_VAL(4'b0010)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({wp_n, si, cs_n, sck}),
    .rst_ln   (rst_ln),
    .lvl      (pin_s)
  );

  assign sck_s = pin_s[0];
  assign csn_s = pin_s[1];
  assign si_s  = pin_s[2];
  assign wpn_s = pin_s[3];

  logic sck_d_q, csn_d_q;
  logic sck_rise, sck_fall, cs_close;

  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign cs_close = csn_s & ~csn_d_q;

  // controller state
  ee_state_e        state_q, state_d;
  ee_job_e          job_q, job_d;
  logic [2:0]       bit_q, bit_d;
  logic [6:0]       sh_q, sh_d;
  logic             rd_op_q, rd_op_d;
  logic             a8_q, a8_d;
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [7:0]       out_q, out_d;
  logic             oe_q, oe_d;
  logic             wel_q, wel_d;
  logic             lset_q, lset_d;
  logic [1:0]       wd_q, wd_d;
  logic [1:0]       bl_q, bl_d;
  logic [3:0]       swd_q, swd_d;
  logic             sgot_q, sgot_d;
  logic [GW-1:0]    page_q, page_d;
  logic [PAGE_BYTES-1:0] vmask_q, vmask_d;
  logic [7:0]       pbuf_q [PAGE_BYTES];
  logic [7:0]       pbuf_d [PAGE_BYTES];
  logic [7:0]       mem_q  [DEPTH];

  logic       busy, done, start, prot;
  logic [7:0] byte_in, status;

  spi_ee_guard #(.AW(AW)) u_guard (
    .lock (bl_q),
    .addr (ptr_q),
    .prot (prot)
  );

  spi_ee_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk    (clk),
    .rst_ln (rst_ln),
    .start  (start),
    .busy   (busy),
    .done   (done)
  );

  assign byte_in = {sh_q, si_s};
  assign status  = {2'b00, wd_q, bl_q, wel_q, busy};

  // next-state logic
  always_comb begin
    state_d = state_q;
    job_d   = job_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    rd_op_d = rd_op_q;
    a8_d    = a8_q;
    ptr_d   = ptr_q;
    out_d   = out_q;
    oe_d    = oe_q;
    wel_d   = wel_q;
    lset_d  = lset_q;
    wd_d    = wd_q;
    bl_d    = bl_q;
    swd_d   = swd_q;
    sgot_d  = sgot_q;
    page_d  = page_q;
    vmask_d = vmask_q;
    pbuf_d  = pbuf_q;
    start   = 1'b0;

    if (csn_s) begin
      if (cs_close) begin
        unique case (state_q)
          ST_LATCH: if (bit_q == 3'd0) wel_d = lset_q;
          ST_WDA: begin
            if (bit_q == 3'd0 && (|vmask_q) && wel_q && wpn_s && !prot) begin
              start  = 1'b1;
              job_d  = JOB_ARRAY;
              page_d = ptr_q[AW-1:PW];
            end
          end
          ST_WST: begin
            if (bit_q == 3'd0 && sgot_q && wel_q && wpn_s) begin
              start = 1'b1;
              job_d = JOB_STAT;
            end
          end
          default: ;
        endcase
      end
      state_d = ST_OPC;
      bit_d   = 3'd0;
      oe_d    = 1'b0;
    end else begin
      if (sck_rise) begin
        sh_d  = {sh_q[5:0], si_s};
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          unique case (state_q)
            ST_OPC: begin
              if (busy) begin
                state_d = (byte_in == OP_STAT_RD) ? ST_RST : ST_SKIP;
              end else if (byte_in == OP_LATCH_ON) begin
                state_d = ST_LATCH;
                lset_d  = 1'b1;
              end else if (byte_in == OP_LATCH_OFF) begin
                state_d = ST_LATCH;
                lset_d  = 1'b0;
              end else if (byte_in == OP_STAT_RD) begin
                state_d = ST_RST;
              end else if (byte_in == OP_STAT_WR) begin
                state_d = ST_WST;
                sgot_d  = 1'b0;
              end else if (byte_in[7:4] == 4'h0 &&
                           (byte_in[2:0] == OP_LO_READ || byte_in[2:0] == OP_LO_WRITE)) begin
                state_d = ST_ADR;
                rd_op_d = byte_in[0];
                a8_d    = byte_in[3];
              end else begin
                state_d = ST_SKIP;
              end
            end
            ST_ADR: begin
              ptr_d   = {a8_q, byte_in};
              vmask_d = '0;
              state_d = rd_op_q ? ST_RDA : ST_WDA;
            end
            ST_WDA: begin
              pbuf_d[ptr_q[PW-1:0]]  = byte_in;
              vmask_d[ptr_q[PW-1:0]] = 1'b1;
              ptr_d[PW-1:0]          = ptr_q[PW-1:0] + PONE;
            end
            ST_WST: begin
              swd_d  = byte_in[5:2];
              sgot_d = 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (sck_fall && (state_q == ST_RDA || state_q == ST_RST)) begin
        if (bit_q == 3'd0) begin
          oe_d = 1'b1;
          if (state_q == ST_RDA) begin
            out_d = mem_q[ptr_q];
            ptr_d = ptr_q + AONE;
          end else begin
            out_d = status;
          end
        end else begin
          out_d = {out_q[6:0], 1'b0};
        end
      end
    end

    if (done) begin
      wel_d = 1'b0;
      if (job_q == JOB_STAT) {wd_d, bl_d} = swd_q;
    end
    if (!wpn_s) wel_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      sck_d_q <= 1'b0;
      csn_d_q <= 1'b1;
      state_q <= ST_OPC;
      job_q   <= JOB_ARRAY;
      bit_q   <= 3'd0;
      sh_q    <= '0;
      rd_op_q <= 1'b0;
      a8_q    <= 1'b0;
      ptr_q   <= '0;
      out_q   <= '0;
      oe_q    <= 1'b0;
      wel_q   <= 1'b0;
      lset_q  <= 1'b0;
      wd_q    <= 2'b11;
      bl_q    <= 2'b00;
      swd_q   <= '0;
      sgot_q  <= 1'b0;
      page_q  <= '0;
      vmask_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= '0;
    end else begin
      sck_d_q <= sck_s;
      csn_d_q <= csn_s;
      state_q <= state_d;
      job_q   <= job_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rd_op_q <= rd_op_d;
      a8_q    <= a8_d;
      ptr_q   <= ptr_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
      wel_q   <= wel_d;
      lset_q  <= lset_d;
      wd_q    <= wd_d;
      bl_q    <= bl_d;
      swd_q   <= swd_d;
      sgot_q  <= sgot_d;
      page_q  <= page_d;
      vmask_q <= vmask_d;
      pbuf_q  <= pbuf_d;
    end
  end

  // storage array: contents survive reset, updated at the end of a cycle
  always_ff @(posedge clk) begin
    if (done && job_q == JOB_ARRAY) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (vmask_q[i]) mem_q[{page_q, PW'(i)}] <= pbuf_q[i];
      end
    end
  end

  assign so     = out_q[7];
  assign so_oe  = oe_q;
  assign wd_sel = wd_q;

  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    csn_s |=> !so_oe);

  // R2
  wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    $rose(wel_q) |-> $past(cs_close));

  // R7
  wp_wel_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    !wpn_s |=> !wel_q);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    $rose(busy) |-> $past(cs_close) && $past(wel_q));

  // R6
  busy_align_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    $rose(busy) |-> $past(bit_q) == 3'd0);

  // R10
  busy_state_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    busy |-> !(state_q inside {ST_ADR, ST_RDA, ST_WDA, ST_WST, ST_LATCH}));

endmodule

// File: tb/sim_spi_ee_ctrl.sv
`timescale 1ns/1ps
module sim_spi_ee_ctrl;

  localparam int WRC   = 1000;
  localparam int HALF  = 5;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  logic [1:0] wd_sel;

  always #2.5 clk = ~clk;

  spi_ee_ctrl #(.PAGE_BYTES(16), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .wp_n(wp_n), .so(so), .so_oe(so_oe), .wd_sel(wd_sel)
  );

  int checks = 0, errors = 0;
  logic [7:0] mdl [512];
  logic [7:0] rbuf [600];
  logic [7:0] st;
  logic       oe_acc;
  logic       finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0; oe_acc = 1'b0; clks(HALF);
  endtask

  task automatic desel();
    cs_n = 1'b1; clks(8);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      rx[i] = so;
      oe_acc = oe_acc | so_oe;
      sck = 1'b1; clks(HALF);
      sck = 1'b0; clks(HALF);
    end
  endtask

  task automatic tx1(input logic [7:0] tx);
    logic [7:0] dummy;
    xfer(tx, dummy);
  endtask

  task automatic loose_bits(input int n);
    for (int i = 0; i < n; i++) begin
      si = 1'b1;
      sck = 1'b1; clks(HALF);
      sck = 1'b0; clks(HALF);
    end
  endtask

  task automatic rdsr(output logic [7:0] s);
    sel(); tx1(8'h05); xfer(8'h00, s); desel();
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); tx1(op); desel();
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 29) + (a >> 3) + salt);
  endfunction

  task automatic wr_hdr(input int a);
    tx1({4'h0, 1'(a >> 8), 3'b010});
    tx1(8'(a));
  endtask

  // writes n bytes pat(a+k, salt) from address a, updating the model if commit is expected
  task automatic wr_seq(input int a, input int n, input int salt, input bit upd);
    sel(); wr_hdr(a);
    for (int k = 0; k < n; k++) begin
      int t;
      t = (a & 9'h1F0) | ((a + k) & 15);
      tx1(pat(a + k, salt));
      if (upd) mdl[t] = pat(a + k, salt);
    end
    desel();
  endtask

  task automatic rd_seq(input int a, input int n, output logic hdr_oe);
    logic [7:0] r;
    sel();
    tx1({4'h0, 1'(a >> 8), 3'b011});
    tx1(8'(a));
    hdr_oe = oe_acc;
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      rbuf[k] = r;
    end
    desel();
  endtask

  task automatic wait_done(input string req);
    logic [7:0] s;
    int polls;
    polls = 0;
    rdsr(s);
    while (s[0] && polls < 30) begin
      rdsr(s);
      polls++;
    end
    chk(req, {31'd0, s[0]}, 32'd0);
  endtask

  task automatic rd_cmp(input string req, input int a, input int n);
    logic h;
    rd_seq(a, n, h);
    for (int k = 0; k < n; k++) chk(req, rbuf[k], mdl[(a + k) & 511]);
  endtask

  task automatic wrsr(input logic [7:0] v);
    sel(); tx1(8'h01); tx1(v); desel();
  endtask

  initial begin : watchdog
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic h;
    int pages [10] = '{9'h000, 9'h010, 9'h020, 9'h030, 9'h0F0,
                      9'h180, 9'h1C0, 9'h1D0, 9'h1E0, 9'h1F0};
    int taddr [6]  = '{9'h000, 9'h030, 9'h0F0, 9'h100, 9'h180, 9'h1F0};
    clks(4);
    rst_n = 1'b1;
    clks(10);

    // R1 R3 reset state
    chk("R1", {31'd0, so_oe}, 32'd0);
    chk("R3", {30'd0, wd_sel}, 32'd3);
    rdsr(st); chk("R3", st, 8'h30);

    // R2 latch set/clear and partial-byte cancel
    cmd1(8'h06); rdsr(st); chk("R2", st, 8'h32);
    cmd1(8'h04); rdsr(st); chk("R2", st, 8'h30);
    sel(); tx1(8'h06); loose_bits(3); desel();
    rdsr(st); chk("R2", st, 8'h30);

    // R5 R9 fill ten pages
    for (int p = 0; p < 10; p++) begin
      cmd1(8'h06);
      wr_seq(pages[p], 16, 0, 1'b1);
      rdsr(st);
      chk("R9", st, 8'h33);
      wait_done("R9");
      rdsr(st);
      chk("R9", st, 8'h30);
    end

    // R4 R1 sequential read with wrap past 1FFh
    rd_seq(9'h1C0, 128, h);
    chk("R1", {31'd0, h}, 32'd0);
    chk("R1", {31'd0, so_oe}, 32'd0);
    for (int k = 0; k < 128; k++) chk("R4", rbuf[k], mdl[(9'h1C0 + k) & 511]);

    // R5 page wrap: 20 bytes from 105h
    cmd1(8'h06);
    wr_seq(9'h105, 20, 8'h55, 1'b1);
    wait_done("R5");
    rd_cmp("R5", 9'h100, 16);

    // R6 trailing partial byte discards write, latch stays set
    cmd1(8'h06);
    sel(); wr_hdr(9'h020); tx1(8'hA5); tx1(8'h5A); loose_bits(5); desel();
    rdsr(st); chk("R6", st, 8'h32);
    rd_cmp("R6", 9'h020, 4);
    sel(); wr_hdr(9'h021); desel();
    rdsr(st); chk("R6", st, 8'h32);
    rd_cmp("R6", 9'h020, 4);
    cmd1(8'h04);

    // R7 no latch, WP low
    wr_seq(9'h030, 4, 8'h77, 1'b0);
    rdsr(st); chk("R7", st, 8'h30);
    rd_cmp("R7", 9'h030, 4);
    cmd1(8'h06); wp_n = 1'b0; clks(10);
    rdsr(st); chk("R7", st, 8'h30);
    cmd1(8'h06); rdsr(st); chk("R7", st, 8'h30);
    wp_n = 1'b1; clks(4);
    cmd1(8'h06);
    sel(); wr_hdr(9'h031); tx1(8'hC3); wp_n = 1'b0; clks(6); desel();
    rdsr(st); chk("R7", st, 8'h30);
    rd_cmp("R7", 9'h030, 4);
    wp_n = 1'b1; clks(4);

    // R11 status writes
    cmd1(8'h06); wrsr(8'hFF);
    rdsr(st); chk("R11", st, 8'h33);
    wait_done("R11");
    rdsr(st); chk("R11", st, 8'h3C);
    chk("R3", {30'd0, wd_sel}, 32'd3);
    cmd1(8'h06); wrsr(8'hC3); wait_done("R11");
    rdsr(st); chk("R11", st, 8'h00);
    chk("R3", {30'd0, wd_sel}, 32'd0);
    cmd1(8'h06);
    sel(); tx1(8'h01); tx1(8'h3C); loose_bits(2); desel();
    rdsr(st); chk("R6", st, 8'h02);
    cmd1(8'h04);

    // R8 sweep of lock codes against addresses on both sides
    for (int code = 0; code < 4; code++) begin
      cmd1(8'h06); wrsr(8'(code << 2)); wait_done("R8");
      rdsr(st); chk("R8", st, 32'(code << 2));
      for (int j = 0; j < 6; j++) begin
        bit p;
        p = (code == 3) || (code == 2 && taddr[j] >= 9'h100) ||
            (code == 1 && taddr[j] >= 9'h180);
        cmd1(8'h06);
        wr_seq(taddr[j] + 3, 1, 16 * code + j, !p);
        rdsr(st);
        if (p) begin
          chk("R8", st, 32'((code << 2) | 2));
          cmd1(8'h04);
        end else begin
          chk("R8", st, 32'((code << 2) | 3));
          wait_done("R8");
        end
        rd_cmp("R8", taddr[j], 4);
      end
    end
    cmd1(8'h06); wrsr(8'h30); wait_done("R11");
    rdsr(st); chk("R11", st, 8'h30);
    chk("R3", {30'd0, wd_sel}, 32'd3);

    // R10 commands ignored while busy
    cmd1(8'h06);
    wr_seq(9'h010, 16, 8'h19, 1'b1);
    sel(); wr_hdr(9'h020); tx1(8'hEE); desel();
    rd_seq(9'h000, 2, h);
    chk("R10", {31'd0, oe_acc}, 32'd0);
    cmd1(8'h04);
    rdsr(st); chk("R10", st, 8'h33);
    cmd1(8'h06);
    wrsr(8'h0C);
    wait_done("R10");
    rdsr(st); chk("R10", st, 8'h30);
    rd_cmp("R10", 9'h010, 16);
    rd_cmp("R10", 9'h020, 2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule